// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address. It reads page-table entries through a single memory port. A walk starts from a per-context root entry and then descends through up to three levels of tables. The walk stops at the first page entry it finds. A page entry at the first level maps a 16 MB page, one at the second level maps a 256 KB page, and one at the third level maps a 4 KB page. When the enable input is low, the block skips the memory and passes the address straight through.

A request is accepted on a valid/ready handshake and one walk runs at a time. The result is held on a valid/ready output until the consumer takes it. The result carries the physical address, the three-bit access field of the page entry and a fault code. The fault code gives the level and the kind of bad entry. When a page entry is found whose referenced bit is clear, or whose modified bit is clear on a write, the walker sets those bits and writes the entry back before it responds.

Entry layout: bits [31:8] hold the physical page number, bit 6 is the modified bit, bit 5 is the referenced bit, bits [4:2] hold the access field and bits [1:0] hold the type. The type values are 0 invalid, 1 table pointer, 2 page entry and 3 reserved.

Top module: `pgw_walker`

## Requirements
- R1: With `cfg_enable` low when a request is accepted, the result has `rsp_paddr` equal to the zero-extended virtual address, `rsp_perm` = 3 (read/write) and `rsp_fault` = 0, and no memory access is made.
- R2: The root entry is read from `cfg_ctx_ptr`*16 + `cfg_ctx_num`*16. Both configuration inputs are sampled only in the cycle the request is accepted.
- R3: A table-pointer entry (type 1) at level L gives the next table base {entry[31:2], 6'b0}. The next read goes to that base + 4*index, where the index is va[31:24] after the root, va[23:18] after level 1 and va[17:12] after level 2.
- R4: A page entry (type 2) gives `rsp_paddr` = {entry[31:8], 12'b0} + offset. The offset is va[23:0] at level 1, va[17:0] at level 2 and va[11:0] at level 3.
- R5: On a successful walk, `rsp_perm` equals bits [4:2] of the page entry.
- R6: A fault code is {level[1:0], 3'b000, kind[2:0], 2'b00}, where kind is 1 for an invalid entry (type 0) and 4 for a reserved entry (type 3). On a fault, `rsp_paddr` and `rsp_perm` are zero.
- R7: At the root level, any entry that is not a table pointer faults: type 0 and type 2 give 0x004, and type 3 gives 0x010.
- R8: A table-pointer entry at level 3 faults with code 0x310.
- R9: If the page entry has bit 5 clear, or the access is a write and bit 6 is clear, the walker writes the entry back to the address it was read from before responding. The written value has bit 5 set, and bit 6 also set on a write. Otherwise no write is made.
- R10: `req_ready` is high only while no walk or result is pending, so one walk is in flight at a time.
- R11: `mem_req_valid` stays high with address, kind and data unchanged until `mem_req_ready`. Addresses are word-aligned. Each accepted read is answered by one cycle of `mem_rsp_valid`. Writes get no response.
- R12: `rsp_valid` stays high with unchanged `rsp_paddr`, `rsp_perm` and `rsp_fault` until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| cfg_enable | input | 1 | Translation enable; low selects bypass |
| cfg_ctx_ptr | input | 32 | Root table pointer (byte address / 16) |
| cfg_ctx_num | input | CTX_W | Current context number |
| mem_req_valid | output | 1 | Memory access request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_addr | output | 36 | Entry byte address |
| mem_req_wdata | output | 32 | Write-back entry value |
| mem_rsp_valid | input | 1 | Read data valid (one cycle per read) |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 36 | Physical address |
| rsp_perm | output | 3 | Access field of the page entry |
| rsp_fault | output | 10 | Fault code, zero on success |

## Verification
The properties assume that the memory raises `mem_rsp_valid` only for a read it has accepted and has not yet answered, and exactly once for each such read. The bench memory model keeps this by holding at most one read outstanding, with pseudo-random acceptance and a latency of one to four cycles. It never answers a write. The tables are laid out so that every entry type shows up at every level, and every walk in the sweep is compared against an arithmetic model of the entry format.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int VA_W    = 32;
  localparam int PTE_W   = 32;
  localparam int PA_W    = 36;
  localparam int FLT_W   = 10;
  localparam int ACC_LSB = 2;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam logic [1:0] LAST_LVL = 2'd3;

  localparam logic [2:0] FT_INVALID  = 3'd1;
  localparam logic [2:0] FT_RESERVED = 3'd4;
  localparam logic [2:0] PERM_RW     = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_UPDATE, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RSVD = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    ACT_NEXT, ACT_LEAF, ACT_FAULT
  } dec_act_e;

  function automatic walk_st_e step_st(walk_st_e s);
    case (s)
      ST_CTX:  return ST_L1;
      ST_L1:   return ST_L2;
      default: return ST_L3;
    endcase
  endfunction

endpackage

// File: rtl/pgw_entry_decode.sv
module pgw_entry_decode
  import pgw_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  input  logic [1:0]       level,
  input  logic             is_write,
  output dec_act_e         act,
  output logic [FLT_W-1:0] fault,
  output logic             need_wb,
  output logic [PTE_W-1:0] wb_data
);

  ent_type_e  etype;
  logic [2:0] ftype;

  assign etype = ent_type_e'(entry[1:0]);

  always_comb begin
    act   = ACT_FAULT;
    ftype = FT_INVALID;
    case (etype)
      ET_PTD: begin
        if (level == LAST_LVL) ftype = FT_RESERVED;
        else                   act   = ACT_NEXT;
      end
      ET_PTE: begin
        if (level != 2'd0) act = ACT_LEAF;
      end
      ET_RSVD: ftype = FT_RESERVED;
      default: ftype = FT_INVALID;
    endcase
  end

  assign fault = {level, 3'b000, ftype, 2'b00};

  assign need_wb = (act == ACT_LEAF) &&
                   (!entry[REF_BIT] || (is_write && !entry[MOD_BIT]));

  always_comb begin
    wb_data          = entry;
    wb_data[REF_BIT] = 1'b1;
    if (is_write) wb_data[MOD_BIT] = 1'b1;
  end

endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [VA_W-1:0]  va,
  input  logic [PTE_W-1:2] ptr_bits,
  input  logic [1:0]       level,
  output logic [PA_W-1:0]  ctx_addr,
  output logic [PA_W-1:0]  next_addr,
  output logic [PA_W-1:0]  leaf_pa
);

  localparam int ROW_SH  = 4;
  localparam int BASE_SH = 6;
  localparam int PG_SH   = 12;

  logic [7:0]  idx;
  logic [23:0] off;

  assign ctx_addr = {ctx_ptr, {ROW_SH{1'b0}}} + PA_W'({ctx_num, {ROW_SH{1'b0}}});

  always_comb begin
    case (level)
      2'd0:    idx = va[31:24];
      2'd1:    idx = {2'b00, va[23:18]};
      default: idx = {2'b00, va[17:12]};
    endcase
  end

  assign next_addr = {ptr_bits, {BASE_SH{1'b0}}} + PA_W'({idx, 2'b00});

  always_comb begin
    case (level)
      2'd1:    off = va[23:0];
      2'd2:    off = {6'b0, va[17:0]};
      default: off = {12'b0, va[11:0]};
    endcase
  end

  assign leaf_pa = {ptr_bits[PTE_W-1:8], {PG_SH{1'b0}}} + PA_W'(off);

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             cfg_enable,
  input  logic [31:0]      cfg_ctx_ptr,
  input  logic [CTX_W-1:0] cfg_ctx_num,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_perm,
  output logic [FLT_W-1:0] rsp_fault
);

  walk_st_e         st_q;
  logic             issued_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  pa_q;
  logic [PTE_W-1:0] wb_q;
  logic [2:0]       perm_q;
  logic [FLT_W-1:0] flt_q;

  logic             walking;
  logic [1:0]       lvl;
  dec_act_e         dec_act;
  logic [FLT_W-1:0] dec_fault;
  logic             dec_wb;
  logic [PTE_W-1:0] dec_wb_data;
  logic [PA_W-1:0]  ctx_addr;
  logic [PA_W-1:0]  next_addr;
  logic [PA_W-1:0]  leaf_pa;

  assign walking = (st_q == ST_CTX) || (st_q == ST_L1) ||
                   (st_q == ST_L2)  || (st_q == ST_L3);

  always_comb begin
    case (st_q)
      ST_L1:   lvl = 2'd1;
      ST_L2:   lvl = 2'd2;
      ST_L3:   lvl = 2'd3;
      default: lvl = 2'd0;
    endcase
  end

  pgw_entry_decode u_dec (
    .entry    (mem_rsp_data),
    .level    (lvl),
    .is_write (wr_q),
    .act      (dec_act),
    .fault    (dec_fault),
    .need_wb  (dec_wb),
    .wb_data  (dec_wb_data)
  );

  pgw_addr_gen #(.CTX_W(CTX_W)) u_agen (
    .ctx_ptr   (cfg_ctx_ptr),
    .ctx_num   (cfg_ctx_num),
    .va        (va_q),
    .ptr_bits  (mem_rsp_data[PTE_W-1:2]),
    .level     (lvl),
    .ctx_addr  (ctx_addr),
    .next_addr (next_addr),
    .leaf_pa   (leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      pa_q     <= '0;
      wb_q     <= '0;
      perm_q   <= '0;
      flt_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            issued_q <= 1'b0;
            if (cfg_enable) begin
              addr_q <= ctx_addr;
              st_q   <= ST_CTX;
            end else begin
              pa_q   <= PA_W'(req_vaddr);
              perm_q <= PERM_RW;
              flt_q  <= '0;
              st_q   <= ST_DONE;
            end
          end
        end
        ST_UPDATE: begin
          if (mem_req_ready) st_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: begin
          if (!issued_q && mem_req_ready) issued_q <= 1'b1;
          if (issued_q && mem_rsp_valid) begin
            issued_q <= 1'b0;
            case (dec_act)
              ACT_NEXT: begin
                addr_q <= next_addr;
                st_q   <= step_st(st_q);
              end
              ACT_LEAF: begin
                pa_q   <= leaf_pa;
                perm_q <= mem_rsp_data[ACC_LSB +: 3];
                flt_q  <= '0;
                wb_q   <= dec_wb_data;
                st_q   <= dec_wb ? ST_UPDATE : ST_DONE;
              end
              default: begin
                pa_q   <= '0;
                perm_q <= '0;
                flt_q  <= dec_fault;
                st_q   <= ST_DONE;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (walking && !issued_q) || (st_q == ST_UPDATE);
  assign mem_req_write = (st_q == ST_UPDATE);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wb_q;
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_paddr     = pa_q;
  assign rsp_perm      = perm_q;
  assign rsp_fault     = flt_q;

endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk
  import pgw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [2:0]       rsp_perm,
  input logic [FLT_W-1:0] rsp_fault
);

  // R10
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

  // R11
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R9
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[REF_BIT]);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm) && $stable(rsp_fault)));

  // R6
  flt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != '0) |->
      (rsp_paddr == '0 && rsp_perm == 3'd0 && rsp_fault[1:0] == 2'b00));

endmodule

bind pgw_walker pgw_walker_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_perm      (rsp_perm),
  .rsp_fault     (rsp_fault)
);

// File: tb/pgw_walker_tb_top.sv
`timescale 1ns/1ps
module pgw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_ctx_ptr = '0;
  logic [7:0]  cfg_ctx_num = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [9:0]  rsp_fault;

  always #4 clk = ~clk;

  pgw_walker #(.CTX_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .cfg_enable(cfg_enable), .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  // table memory and bench counters
  logic [31:0] tmem [logic [35:0]];
  int checks = 0, fails = 0, wr_count = 0, acc_count = 0, misalign = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] rd(input logic [35:0] a);
    return tmem.exists(a) ? tmem[a] : 32'h0;
  endfunction

  // memory model: pseudo-random acceptance, one outstanding read, 1..4 cycle latency
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [1:0]  pend_cnt = '0;
  logic [31:0] pend_data = '0;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
      mem_req_ready <= 1'b0;
    end else begin
      mem_req_ready <= lfsr[0] | lfsr[3];
      if (pend) begin
        if (pend_cnt == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= pend_data;
          pend <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 2'd1;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        acc_count = acc_count + 1;
        if (mem_req_addr[1:0] != 2'b00) misalign = misalign + 1;
        if (mem_req_write) begin
          tmem[mem_req_addr] = mem_req_wdata;
          wr_count = wr_count + 1;
        end else begin
          pend      <= 1'b1;
          pend_cnt  <= lfsr[2:1];
          pend_data <= rd(mem_req_addr);
        end
      end
    end
  end

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // arithmetic model of the entry format
  function automatic void ref_walk(input logic [31:0] va, input logic wr,
      input logic [31:0] cptr, input logic [7:0] cnum,
      output logic [35:0] pa, output logic [2:0] perm, output logic [9:0] flt,
      output logic wb, output logic [35:0] wa, output logic [31:0] wv);
    logic [35:0] a;
    logic [31:0] e;
    logic [35:0] idx;
    logic [35:0] off;
    pa = '0; perm = '0; flt = '0; wb = 1'b0; wa = '0; wv = '0;
    a = {cptr, 4'b0} + {24'b0, cnum, 4'b0};
    e = rd(a);
    if (e[1:0] != 2'd1) begin
      flt = (e[1:0] == 2'd3) ? 10'h010 : 10'h004;
      return;
    end
    for (int lv = 1; lv <= 3; lv++) begin
      if (lv == 1)      idx = {28'b0, va[31:24]};
      else if (lv == 2) idx = {30'b0, va[23:18]};
      else              idx = {30'b0, va[17:12]};
      a = {e[31:2], 6'b0} + (idx << 2);
      e = rd(a);
      case (e[1:0])
        2'd0: begin flt = {2'(lv), 8'h04}; return; end
        2'd3: begin flt = {2'(lv), 8'h10}; return; end
        2'd1: if (lv == 3) begin flt = 10'h310; return; end
        default: begin
          if (lv == 1)      off = {12'b0, va[23:0]};
          else if (lv == 2) off = {18'b0, va[17:0]};
          else              off = {24'b0, va[11:0]};
          pa   = {e[31:8], 12'b0} + off;
          perm = e[4:2];
          if (!e[5] || (wr && !e[6])) begin
            wb = 1'b1;
            wa = a;
            wv = e | 32'h20 | (wr ? 32'h40 : 32'h0);
          end
          return;
        end
      endcase
    end
  endfunction

  function automatic logic [31:0] mk_pte(input int i, input int j, input int k);
    logic [2:0]  s;
    logic [2:0]  acc;
    logic [23:0] ppn;
    s   = 3'(i + j + k);
    acc = 3'(3 * i + 5 * j + k);
    ppn = 24'h0A0000 + 24'(i * 4096 + j * 64 + k);
    return {ppn, 1'b0, s[1], s[0], acc, 2'b10};
  endfunction

  function automatic logic [31:0] mk_ptd(input logic [35:0] base);
    return 32'(base >> 4) | 32'h1;
  endfunction

  task automatic do_walk(input logic [31:0] va, input logic wr, input int hold,
      input int alt_ctx, output logic [35:0] pa, output logic [2:0] perm, output logic [9:0] flt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (alt_ctx >= 0) cfg_ctx_num = 8'(alt_ctx);
    chk_eq("R10 req_ready low while busy", 64'(req_ready), 64'd0);
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; perm = rsp_perm; flt = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk_eq("R12 result held", {27'b0, rsp_valid, rsp_paddr},
             {27'b0, 1'b1, pa});
      chk_eq("R12 fault held", 64'({perm, flt}), 64'({rsp_perm, rsp_fault}));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [35:0] gpa, epa, ewa;
    logic [2:0]  gperm, eperm;
    logic [9:0]  gflt, eflt;
    logic        ewb;
    logic [31:0] ewv, va;
    int          wc0, ac0;

    // tables: root at 0x10000, level-1 table at 0x20000
    tmem[36'h10000] = mk_ptd(36'h20000);
    tmem[36'h10010] = 32'h0;
    tmem[36'h10020] = mk_pte(7, 7, 7);
    tmem[36'h10030] = 32'h0000_0AB3;
    for (int i = 0; i < 8; i++) begin
      logic [35:0] b2;
      b2 = 36'h30000 + 36'(i * 36'h400);
      case (i % 4)
        0: tmem[36'h20000 + 36'(i * 4)] = 32'h0;
        1: tmem[36'h20000 + 36'(i * 4)] = mk_ptd(b2);
        2: tmem[36'h20000 + 36'(i * 4)] = mk_pte(i, 0, 0);
        default: tmem[36'h20000 + 36'(i * 4)] = 32'h0000_ABC3;
      endcase
      for (int j = 0; j < 8; j++) begin
        logic [35:0] b3;
        b3 = 36'h40000 + 36'((i * 8 + j) * 36'h100);
        case (j % 4)
          0: tmem[b2 + 36'(j * 4)] = 32'h0;
          1: tmem[b2 + 36'(j * 4)] = mk_ptd(b3);
          2: tmem[b2 + 36'(j * 4)] = mk_pte(i, j, 0);
          default: tmem[b2 + 36'(j * 4)] = 32'h0000_1233;
        endcase
        for (int k = 0; k < 8; k++) begin
          case (k % 4)
            0: tmem[b3 + 36'(k * 4)] = 32'h0;
            1: tmem[b3 + 36'(k * 4)] = 32'h0050_0001;
            2: tmem[b3 + 36'(k * 4)] = mk_pte(i, j, k);
            default: tmem[b3 + 36'(k * 4)] = 32'h0000_7773;
          endcase
        end
      end
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10 reset req_ready", 64'(req_ready), 64'd1);
    chk_eq("R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk_eq("R11 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R1: bypass
    cfg_enable = 1'b0;
    ac0 = acc_count;
    for (int n = 0; n < 8; n++) begin
      va = 32'(32'h1357_9BDF * (n + 1)) ^ ((n == 7) ? 32'hFFFF_FFFF : 32'h0);
      do_walk(va, n[0], 0, -1, gpa, gperm, gflt);
      chk_eq("R1 bypass paddr", 64'(gpa), 64'({4'b0, va}));
      chk_eq("R1 bypass perm", 64'(gperm), 64'd3);
      chk_eq("R1 bypass fault", 64'(gflt), 64'd0);
    end
    chk_eq("R1 no memory access", 64'(acc_count - ac0), 64'd0);

    // R7: root-level faults
    cfg_enable = 1'b1;
    cfg_ctx_ptr = 32'h1000;
    for (int c = 1; c < 4; c++) begin
      cfg_ctx_num = 8'(c);
      do_walk(32'h0123_4567, 1'b0, 1, -1, gpa, gperm, gflt);
      chk_eq("R7 root fault", 64'(gflt), (c == 3) ? 64'h010 : 64'h004);
      chk_eq("R6 fault paddr zero", 64'(gpa), 64'd0);
    end
    cfg_ctx_num = 8'd0;

    // main sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          for (int w = 0; w < 2; w++) begin
            va = {8'(i), 6'(j), 6'(k), 12'(i * 291 + j * 37 + k * 5 + w * 7)};
            ref_walk(va, w[0], 32'h1000, 8'd0, epa, eperm, eflt, ewb, ewa, ewv);
            wc0 = wr_count;
            do_walk(va, w[0], ((i + j + k) % 5 == 0) ? 2 : 0, -1, gpa, gperm, gflt);
            chk_eq("R3/R4 paddr", 64'(gpa), 64'(epa));
            chk_eq("R5 perm", 64'(gperm), 64'(eperm));
            if (eflt == 10'h310) chk_eq("R8 level-3 pointer fault", 64'(gflt), 64'(eflt));
            else                 chk_eq("R6 fault code", 64'(gflt), 64'(eflt));
            chk_eq("R9 write-back count", 64'(wr_count - wc0), ewb ? 64'd1 : 64'd0);
            if (ewb) chk_eq("R9 write-back value", 64'(rd(ewa)), 64'(ewv));
          end

    // R2: root address arithmetic and sampling at acceptance
    va = {8'd1, 6'd1, 6'd2, 12'h5A5};
    ref_walk(va, 1'b1, 32'h1000, 8'd0, epa, eperm, eflt, ewb, ewa, ewv);
    cfg_ctx_ptr = 32'h0FFC;
    cfg_ctx_num = 8'd4;
    do_walk(va, 1'b1, 0, 1, gpa, gperm, gflt);
    chk_eq("R2 root address paddr", 64'(gpa), 64'(epa));
    chk_eq("R2 root address fault", 64'(gflt), 64'd0);
    cfg_ctx_num = 8'd0;
    do_walk(va, 1'b0, 0, -1, gpa, gperm, gflt);
    chk_eq("R2 empty root slot", 64'(gflt), 64'h004);

    chk_eq("R11 aligned accesses", 64'(misalign), 64'd0);
    finish_run();
  end

endmodule